// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers up to 32 interrupt lines into one active-high request for a processor. Each line passes through a two-flop synchronizer. A parameter mask marks each line as edge-captured or level-sensed. A captured event sets a bit in a status register. Bits that are both set in status and enabled make up the pending set. The request output is asserted when the master run bit is set and at least one bit is pending.

Software uses a word-addressed port with a 3-bit address and eight 32-bit registers. Enable bits can be loaded whole, or changed atomically through separate set-mask and clear-mask registers. Status bits are cleared by writing ones to the acknowledge register. The vector register gives the lowest-numbered pending source, or all-ones when nothing is pending. A hardware-enable bit controls what can set status bits. While it is clear, software may set status bits directly for test. Once it is set, only the inputs can set them, and it stays set until reset.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and master-control read zero, the vector reads 32'hFFFF_FFFF and irq_req is low.
- R2: Word offsets: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master-control. Offsets 3, 4 and 5 are write-only and read as zero. A write to offset 2 loads enable.
- R3: A write to offset 4 ORs the data into enable and leaves all other enable bits unchanged.
- R4: A write to offset 5 clears the enable bits where the data has ones and leaves all other enable bits unchanged.
- R5: A write to offset 3 clears the status bits where the data has ones. An input event in the same cycle sets its bit anyway.
- R6: Offset 1 reads status AND enable.
- R7: Offset 6 reads the index of the lowest-numbered pending bit, zero-extended. It reads 32'hFFFF_FFFF when no bit is pending.
- R8: irq_req equals master-control bit 0 AND (any pending bit).
- R9: For a line whose EDGE_MASK bit is 1, a rising edge sets its status bit. After an acknowledge, the bit stays clear while the line is held high.
- R10: For a line whose EDGE_MASK bit is 0, the status bit is set on every cycle the synchronized line is high. An acknowledge while the line is high is therefore undone in the next cycle.
- R11: While master-control bit 1 is clear, input events are ignored and a write to offset 0 ORs the data into status. Once bit 1 is set, writes to offset 0 have no effect and only inputs set status bits.
- R12: A write to offset 7 loads bit 0 from data bit 0. It sets bit 1 if data bit 1 is one. Bit 1 never clears except by reset.
- R13: A change on an input reaches status on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Interrupt source lines, asynchronous |
| reg_addr | input | 3 | Register word offset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for reg_addr, combinational from registered state |
| irq_req | output | 1 | Active-high interrupt request to the processor |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a fresh input event. This depends on the synchronizer latency, so it needs the write and the input change to be placed three edges apart. Directed steps cover the fixed ordering cases: an acknowledge while an edge line is held high, and an acknowledge while a level line is held high. A long run then mixes random register writes with sparse random toggling of the input lines, where edge and level lines are mixed. A cycle-accurate bench model is compared on every cycle, and it covers the collisions that these random streams produce.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DW = 32;

    typedef enum logic [2:0] {
        RA_STATUS = 3'd0,
        RA_PEND   = 3'd1,
        RA_ENABLE = 3'd2,
        RA_ACK    = 3'd3,
        RA_SETEN  = 3'd4,
        RA_CLREN  = 3'd5,
        RA_VECTOR = 3'd6,
        RA_MASTER = 3'd7
    } reg_addr_e;

    // master control: bit 0 drives the request, bit 1 lets inputs set status
    typedef struct packed {
        logic hw_on;
        logic run;
    } master_t;

    typedef struct packed {
        logic [DW-1:0] stat;
        logic [DW-1:0] en;
        master_t       mc;
    } ctrl_state_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raw_i,
    output logic [N_SRC-1:0] evt_o
);
    typedef struct packed {
        logic [N_SRC-1:0] s1;
        logic [N_SRC-1:0] s2;
        logic [N_SRC-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = raw_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_kind
        if (EDGE_MASK[i]) begin : g_edge
            assign evt_o[i] = sync_q.s2[i] & ~sync_q.prev[i];
        end else begin : g_level
            assign evt_o[i] = sync_q.s2[i];
        end
    end

    // an edge line cannot report an event on two consecutive cycles
    assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & EDGE_MASK[N_SRC-1:0]) != '0) |=>
        ((evt_o & $past(evt_o) & EDGE_MASK[N_SRC-1:0]) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N_SRC = 32,
    parameter int DW    = 32
) (
    input  logic [N_SRC-1:0] req_i,
    output logic [DW-1:0]    vec_o
);
    always_comb begin
        vec_o = '1;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) vec_o = DW'(i);
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    output logic             irq_req
);
    localparam logic [DW-1:0] VALID = (N_SRC >= DW) ? '1 : DW'((64'd1 << N_SRC) - 64'd1);
    localparam logic [DW-1:0] LVL   = ~EDGE_MASK & VALID;

    ctrl_state_t st_d, st_q;
    logic [N_SRC-1:0] evt;
    logic [DW-1:0]    evt_w;
    logic [DW-1:0]    hw_set;
    logic [DW-1:0]    pend;
    logic [DW-1:0]    vec;
    reg_addr_e        ra;

    irqc_sync #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (irq_in),
        .evt_o (evt)
    );

    assign evt_w  = DW'(evt);
    assign hw_set = st_q.mc.hw_on ? evt_w : '0;
    assign pend   = st_q.stat & st_q.en;
    assign ra     = reg_addr_e'(reg_addr);

    irqc_prio #(.N_SRC(N_SRC), .DW(DW)) u_prio (
        .req_i (pend[N_SRC-1:0]),
        .vec_o (vec)
    );

    always_comb begin
        logic [DW-1:0] sw_set;
        logic [DW-1:0] ack;
        st_d   = st_q;
        sw_set = '0;
        ack    = '0;
        if (reg_wr) begin
            unique case (ra)
                RA_STATUS: if (!st_q.mc.hw_on) sw_set = wr_data & VALID;
                RA_ENABLE: st_d.en = wr_data & VALID;
                RA_ACK:    ack = wr_data;
                RA_SETEN:  st_d.en = st_q.en | (wr_data & VALID);
                RA_CLREN:  st_d.en = st_q.en & ~wr_data;
                RA_MASTER: begin
                    st_d.mc.run   = wr_data[0];
                    st_d.mc.hw_on = st_q.mc.hw_on | wr_data[1];
                end
                default: ;
            endcase
        end
        st_d.stat = (st_q.stat & ~ack) | hw_set | sw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (ra)
            RA_STATUS: rd_data = st_q.stat;
            RA_PEND:   rd_data = pend;
            RA_ENABLE: rd_data = st_q.en;
            RA_VECTOR: rd_data = vec;
            RA_MASTER: rd_data = {30'd0, st_q.mc.hw_on, st_q.mc.run};
            default:   rd_data = '0;
        endcase
    end

    assign irq_req = st_q.mc.run & (|pend);

    assert_seten_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ra == RA_SETEN) |=> (st_q.en == ($past(st_q.en) | ($past(wr_data) & VALID))));

    assert_clren_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ra == RA_CLREN) |=> (st_q.en == ($past(st_q.en) & ~$past(wr_data))));

    assert_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ra == RA_ACK) |=> ((st_q.stat & $past(wr_data) & ~$past(hw_set)) == '0));

    assert_vec_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (st_q.mc.run && vec != '1));

    assert_level_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mc.hw_on |=> ((st_q.stat & $past(evt_w & LVL)) == $past(evt_w & LVL)));

    assert_sw_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mc.hw_on |=> ((st_q.stat & ~$past(st_q.stat) & ~$past(evt_w)) == '0));

    assert_hw_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mc.hw_on |=> st_q.mc.hw_on);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    localparam logic [31:0] EM = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_req;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    logic [31:0] m_s1 = '0, m_s2 = '0, m_s3 = '0, m_stat = '0, m_en = '0;
    logic [1:0]  m_mc = '0;

    irq_vector_ctrl #(.N_SRC(32), .EDGE_MASK(EM)) u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] f_vec(input logic [31:0] p);
        for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] f_read(input logic [2:0] a);
        case (a)
            3'd0: return m_stat;
            3'd1: return m_stat & m_en;
            3'd2: return m_en;
            3'd6: return f_vec(m_stat & m_en);
            3'd7: return {30'd0, m_mc};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic w, input logic [2:0] a, input logic [31:0] d,
                              input logic [31:0] irq);
        logic [31:0] hw, sw, ack;
        hw  = m_mc[1] ? ((m_s2 & ~m_s3 & EM) | (m_s2 & ~EM)) : 32'd0;
        sw  = (w && a == 3'd0 && !m_mc[1]) ? d : 32'd0;
        ack = (w && a == 3'd3) ? d : 32'd0;
        if (w) begin
            case (a)
                3'd2: m_en = d;
                3'd4: m_en = m_en | d;
                3'd5: m_en = m_en & ~d;
                3'd7: m_mc = {m_mc[1] | d[1], d[0]};
                default: ;
            endcase
        end
        m_stat = (m_stat & ~ack) | hw | sw;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq;
    endtask

    // one clock: drive after a falling edge, model at the rising edge, compare at the next fall
    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d,
                       input logic [31:0] irq);
        reg_wr = w; reg_addr = a; wr_data = d; irq_in = irq;
        @(posedge clk);
        model_step(w, a, d, irq);
        @(negedge clk);
        chk("R6 R7 R13 model read", rd_data, f_read(a));
        chk("R8 model irq_req", {31'd0, irq_req}, {31'd0, (m_mc[0] & |(m_stat & m_en))});
    endtask

    task automatic peek(input logic [2:0] a, input string tag, input logic [31:0] exp);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] irq_v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek(3'd0, "R1 status", 32'd0);
        peek(3'd2, "R1 enable", 32'd0);
        peek(3'd7, "R1 master", 32'd0);
        peek(3'd6, "R1 vector", 32'hFFFF_FFFF);
        chk("R1 irq_req", {31'd0, irq_req}, 32'd0);

        cyc(1, 3'd4, 32'h0001_0005, 0);
        peek(3'd2, "R3 set-enable", 32'h0001_0005);
        cyc(1, 3'd5, 32'h0000_0004, 0);
        peek(3'd2, "R4 clear-enable", 32'h0001_0001);
        cyc(1, 3'd0, 32'h0000_0008, 0);
        peek(3'd0, "R11 software status set", 32'h0000_0008);
        peek(3'd6, "R7 vector none pending", 32'hFFFF_FFFF);
        cyc(1, 3'd4, 32'h0000_0008, 0);
        peek(3'd1, "R6 pending", 32'h0000_0008);
        peek(3'd6, "R7 vector index", 32'd3);
        chk("R8 request masked by run bit", {31'd0, irq_req}, 32'd0);
        cyc(1, 3'd7, 32'h1, 0);
        chk("R8 request with run bit", {31'd0, irq_req}, 32'd1);
        cyc(1, 3'd3, 32'h8, 0);
        peek(3'd0, "R5 acknowledge", 32'd0);
        chk("R8 request after ack", {31'd0, irq_req}, 32'd0);
        cyc(1, 3'd7, 32'h3, 0);
        cyc(1, 3'd7, 32'h1, 0);
        peek(3'd7, "R12 hw enable sticky", 32'h3);
        cyc(1, 3'd0, 32'h2, 0);
        peek(3'd0, "R11 software set ignored", 32'd0);
        peek(3'd3, "R2 ack reads zero", 32'd0);
        peek(3'd4, "R2 set-enable reads zero", 32'd0);
        peek(3'd5, "R2 clear-enable reads zero", 32'd0);

        // edge line 0
        cyc(0, 3'd0, 0, 32'h1);
        cyc(0, 3'd0, 0, 32'h1);
        peek(3'd0, "R13 not yet after two edges", 32'd0);
        cyc(0, 3'd0, 0, 32'h1);
        peek(3'd0, "R13 set on third edge", 32'h1);
        peek(3'd6, "R7 vector zero", 32'd0);
        cyc(1, 3'd3, 32'h1, 32'h1);
        repeat (3) cyc(0, 3'd0, 0, 32'h1);
        peek(3'd0, "R9 edge stays clear while held", 32'd0);

        // level line 16
        repeat (3) cyc(0, 3'd0, 0, 32'h0001_0001);
        peek(3'd0, "R10 level sets", 32'h0001_0000);
        peek(3'd6, "R7 vector level", 32'd16);
        cyc(1, 3'd3, 32'h0001_0000, 32'h0001_0001);
        peek(3'd0, "R10 level re-sets after ack", 32'h0001_0000);
        repeat (3) cyc(0, 3'd0, 0, 32'h1);
        cyc(1, 3'd3, 32'h0001_0000, 32'h1);
        cyc(0, 3'd0, 0, 32'h1);
        peek(3'd0, "R10 level clear after release", 32'd0);
        cyc(0, 3'd0, 0, 32'h0);
        repeat (3) cyc(0, 3'd0, 0, 32'h0001_0001);
        peek(3'd0, "R9 new edge plus level", 32'h0001_0001);
        peek(3'd6, "R7 lowest index wins", 32'd0);
        cyc(1, 3'd2, 32'hFFFF_FFFF, 32'h0001_0001);
        peek(3'd2, "R2 enable load", 32'hFFFF_FFFF);

        // random phase checked against the model
        irq_v = 32'h0001_0001;
        for (int k = 0; k < 4000; k++) begin
            logic w;
            logic [2:0] a;
            logic [31:0] d;
            w = ($urandom % 4) == 0;
            a = 3'($urandom);
            d = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
            if (a == 3'd7 && ($urandom % 2) == 0) d = d | 32'h1;
            if (($urandom % 3) == 0) irq_v = irq_v ^ (32'h1 << ($urandom % 32));
            cyc(w, a, d, irq_v);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule